// File: doc/BRIEF.md
# Square Channel Frequency Sweep

This block sweeps the pitch of a square-wave sound channel. It holds the channel's 11-bit frequency value and a sweep control byte, both loaded through a byte-wide register port. A sound frame sequencer supplies a tick strobe together with its current step number. Only steps 2 and 6 count as sweep ticks. A small period divider counts these ticks. When the divider expires, the frequency moves up or down by a right-shifted copy of itself, so each step is proportional to the present pitch. An increase that would go past the 11-bit range halts the sweep and raises a flag that the channel uses to mute itself.

A state machine with three states governs the block. `SW_OFF` is idle, because the period field or the shift field is zero. `SW_RUN` is the state in which the sweep is active. `SW_OVF` holds a latched overflow. The named transitions are:
- OFF→RUN, on a control write whose period and shift are both non-zero.
- RUN→OFF, on a control write in which either field is zero.
- RUN→RUN, on a control write in which both fields are non-zero.
- RUN→OVF, when a divider expiry produces an increase that cannot be represented.
- OVF stays in OVF until reset.

Top module: `sweep_unit`

## Requirements
- R1: Reset clears the frequency, the control fields, the period counter and the overflow flag, and leaves the machine in `SW_OFF`.
- R2: A write to address 1 loads frequency bits 7..0. A write to address 2 loads frequency bits 10..8 from data bits 2..0. Control address 0 takes the period from bits 6..4, the direction from bit 3 (1 = decrease) and the shift n from bits 2..0. Control bit 7 and address 3 have no effect. A written frequency appears on the output one cycle after the write.
- R3: A tick counts only when `seq_tick` is high and `seq_step` is 2 or 6. Any other step, or the strobe held low, leaves the frequency unchanged.
- R4: With a period P, the counter advances by one on each counted tick. The tick that finds the counter equal to P applies the update and returns the counter to 0. Updates therefore land on every (P+1)-th counted tick.
- R5: An update adds or subtracts the current frequency shifted right by n. The result appears on the output one cycle after the tick.
- R6: While the period field or the shift field is zero, ticks never change the frequency.
- R7: A control write returns the period counter to 0.
- R8: An increase whose result exceeds 0x7FF leaves the frequency unchanged and sets `sweep_ovf`. The flag then stays set until reset, and further ticks cause no updates. Frequency writes still take effect while the flag is set. A result of exactly 0x7FF is accepted.
- R9: A register write to any address takes priority over a tick in the same cycle. That tick is dropped and neither advances the counter nor updates the frequency.
- R10: A decrease never sets the overflow flag. When the shifted step is 0, the frequency stays where it is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 frequency low, 2 frequency high) |
| reg_wdata | input | 8 | Write data byte |
| seq_tick | input | 1 | Frame sequencer advance strobe |
| seq_step | input | 3 | Current frame sequencer step |
| freq_out | output | 11 | Current channel frequency value |
| sweep_ovf | output | 1 | Overflow flag that mutes the channel |

## Verification
Two events can fall in the same cycle: a register write and a qualifying sweep tick. The bench provokes this by writing the low frequency byte on the very cycle a step-6 tick arrives while the divider is one tick from expiry. The write must win, and the dropped tick must leave the counter where it was, so the expiry shows up one counted tick later. A behavioural model in the bench judges every cycle, and explicit checks pin both the written value and the delayed update. A second pairing comes from an expiry that overflows: the frequency must hold on the same edge that raises the flag.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
    typedef enum logic [1:0] {
        SW_OFF = 2'd0,
        SW_RUN = 2'd1,
        SW_OVF = 2'd2
    } sweep_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_FLO  = 2'd1;
    localparam logic [1:0] ADDR_FHI  = 2'd2;

    typedef struct packed {
        logic [2:0] period;
        logic       dec;
        logic [2:0] shift;
    } sweep_ctrl_t;
endpackage

// File: rtl/sweep_regs.sv
module sweep_regs
    import sweep_pkg::*;
#(
    parameter int FREQ_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    input  logic              upd_en,
    input  logic [FREQ_W-1:0] upd_val,
    output sweep_ctrl_t       ctrl_q,
    output logic              ctrl_wr,
    output logic [FREQ_W-1:0] freq_q
);
    localparam int HI_W = FREQ_W - 8;

    logic unused_bits;
    assign unused_bits = ^wdata[7:HI_W] ^ wdata[7];

    assign ctrl_wr = we && (addr == ADDR_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= wdata[6:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq_q <= '0;
        end else if (we && addr == ADDR_FLO) begin
            freq_q[7:0] <= wdata;
        end else if (we && addr == ADDR_FHI) begin
            freq_q[FREQ_W-1:8] <= wdata[HI_W-1:0];
        end else if (upd_en) begin
            freq_q <= upd_val;
        end
    end
endmodule

// File: rtl/sweep_div.sv
module sweep_div #(
    parameter int PER_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick_en,
    input  logic [PER_W-1:0] period,
    output logic             fire,
    output logic [PER_W-1:0] cnt_q
);
    assign fire = tick_en && (cnt_q == period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || fire) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sweep_calc.sv
module sweep_calc #(
    parameter int FREQ_W = 11,
    parameter int SH_W   = 3
) (
    input  logic [FREQ_W-1:0] freq,
    input  logic [SH_W-1:0]   shift,
    input  logic              dec,
    output logic [FREQ_W-1:0] next_val,
    output logic              too_big
);
    logic [FREQ_W-1:0] delta;
    logic [FREQ_W:0]   sum;

    always_comb begin
        delta = freq >> shift;
        sum   = {1'b0, freq} + {1'b0, delta};
        if (dec) begin
            next_val = freq - delta;
            too_big  = 1'b0;
        end else begin
            next_val = sum[FREQ_W-1:0];
            too_big  = sum[FREQ_W];
        end
    end
endmodule

// File: rtl/sweep_unit.sv
module sweep_unit
    import sweep_pkg::*;
#(
    parameter int FREQ_W = 11,
    parameter int STEP_W = 3,
    parameter int STEP_A = 2,
    parameter int STEP_B = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              seq_tick,
    input  logic [STEP_W-1:0] seq_step,
    output logic [FREQ_W-1:0] freq_out,
    output logic              sweep_ovf
);
    localparam int PER_W = 3;
    localparam int SH_W  = 3;
    localparam logic [STEP_W-1:0] STEP_A_V = STEP_W'(STEP_A);
    localparam logic [STEP_W-1:0] STEP_B_V = STEP_W'(STEP_B);

    sweep_state_e      state_q, state_d;
    sweep_ctrl_t       ctrl_q;
    logic              ctrl_wr;
    logic [FREQ_W-1:0] freq_q, calc_val;
    logic              calc_big, tick_ok, tick_en, fire, upd_en, fields_on;
    logic [PER_W-1:0]  div_cnt;
    logic [PER_W-1:0]  ctrl_per;
    logic [SH_W-1:0]   ctrl_sh;
    logic              ctrl_dec;

    assign ctrl_per  = ctrl_q.period;
    assign ctrl_sh   = ctrl_q.shift;
    assign ctrl_dec  = ctrl_q.dec;
    assign tick_ok   = seq_tick && !reg_we &&
                       ((seq_step == STEP_A_V) || (seq_step == STEP_B_V));
    assign fields_on = (reg_wdata[6:4] != '0) && (reg_wdata[2:0] != '0);

    sweep_regs #(.FREQ_W(FREQ_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .upd_en(upd_en), .upd_val(calc_val),
        .ctrl_q(ctrl_q), .ctrl_wr(ctrl_wr), .freq_q(freq_q)
    );

    sweep_div #(.PER_W(PER_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(ctrl_wr), .tick_en(tick_en),
        .period(ctrl_per), .fire(fire), .cnt_q(div_cnt)
    );

    sweep_calc #(.FREQ_W(FREQ_W), .SH_W(SH_W)) u_calc (
        .freq(freq_q), .shift(ctrl_sh), .dec(ctrl_dec),
        .next_val(calc_val), .too_big(calc_big)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SW_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_OFF: if (ctrl_wr && fields_on) state_d = SW_RUN;
            SW_RUN: begin
                if (ctrl_wr) begin
                    state_d = fields_on ? SW_RUN : SW_OFF;
                end else if (fire && calc_big) begin
                    state_d = SW_OVF;
                end
            end
            SW_OVF: state_d = SW_OVF;
            default: state_d = SW_OFF;
        endcase
    end

    // outputs
    always_comb begin
        tick_en   = tick_ok && (state_q == SW_RUN);
        upd_en    = fire && !calc_big;
        sweep_ovf = (state_q == SW_OVF);
        freq_out  = freq_q;
    end
endmodule

// File: rtl/sweep_unit_chk.sv
module sweep_unit_chk #(
    parameter int FREQ_W = 11,
    parameter int STEP_W = 3,
    parameter int STEP_A = 2,
    parameter int STEP_B = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              seq_tick,
    input logic [STEP_W-1:0] seq_step,
    input logic [FREQ_W-1:0] freq_out,
    input logic              sweep_ovf,
    input logic [2:0]        cnt,
    input logic [2:0]        per,
    input logic [2:0]        sh,
    input logic              dec
);
    logic counted;
    assign counted = seq_tick &&
        ((seq_step == STEP_W'(STEP_A)) || (seq_step == STEP_W'(STEP_B)));

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_ovf |=> sweep_ovf); // R8
    AST_OVF_HOLDS_FREQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sweep_ovf) |-> $stable(freq_out)); // R8
    AST_IDLE_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && !counted) |=> $stable(freq_out)); // R3
    AST_ZERO_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && (per == 3'd0 || sh == 3'd0)) |=> $stable(freq_out)); // R6
    AST_CTRL_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd0) |=> (cnt == 3'd0)); // R7
    AST_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd1) |=> (freq_out[7:0] == $past(reg_wdata))); // R2
    AST_DEC_NEVER_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && dec) |=> (freq_out <= $past(freq_out))); // R10
    AST_WRITE_DROPS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr != 2'd0) |=> $stable(cnt)); // R9
endmodule

bind sweep_unit sweep_unit_chk #(
    .FREQ_W(FREQ_W), .STEP_W(STEP_W), .STEP_A(STEP_A), .STEP_B(STEP_B)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .seq_tick(seq_tick), .seq_step(seq_step),
    .freq_out(freq_out), .sweep_ovf(sweep_ovf), .cnt(div_cnt),
    .per(ctrl_per), .sh(ctrl_sh), .dec(ctrl_dec)
);

// File: tb/sweep_unit_bench.sv
module sweep_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        seq_tick = 1'b0;
    logic [2:0]  seq_step = '0;
    logic [10:0] freq_out;
    logic        sweep_ovf;

    always #(CLK_PERIOD/2) clk = ~clk;

    sweep_unit u_sweep_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .seq_tick(seq_tick), .seq_step(seq_step),
        .freq_out(freq_out), .sweep_ovf(sweep_ovf)
    );

    int total = 0;
    int bad = 0;
    string tag = "R1";

    // behavioural reference model
    int m_freq = 0, m_per = 0, m_dec = 0, m_sh = 0, m_cnt = 0, m_ovf = 0;
    always @(posedge clk) begin
        int d;
        if (!rst_n) begin
            m_freq = 0; m_per = 0; m_dec = 0; m_sh = 0; m_cnt = 0; m_ovf = 0;
        end else if (reg_we) begin
            d = int'(reg_wdata);
            if (reg_addr == 2'd0) begin
                m_per = (d >> 4) & 7; m_dec = (d >> 3) & 1; m_sh = d & 7; m_cnt = 0;
            end else if (reg_addr == 2'd1) begin
                m_freq = (m_freq & 'h700) | d;
            end else if (reg_addr == 2'd2) begin
                m_freq = (m_freq & 'hFF) | ((d & 7) << 8);
            end
        end else if (seq_tick && (seq_step == 3'd2 || seq_step == 3'd6) &&
                     m_ovf == 0 && m_per != 0 && m_sh != 0) begin
            if (m_cnt == m_per) begin
                m_cnt = 0;
                d = m_freq >> m_sh;
                if (m_dec != 0) m_freq = m_freq - d;
                else if (m_freq + d > 'h7FF) m_ovf = 1;
                else m_freq = m_freq + d;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(bit we, int a, int d, bit tk, int st);
        reg_we = we; reg_addr = a[1:0]; reg_wdata = d[7:0];
        seq_tick = tk; seq_step = st[2:0];
        @(negedge clk);
        chk(tag, int'(freq_out), m_freq);
        chk(tag, int'(sweep_ovf), m_ovf);
    endtask

    task automatic wr(int a, int d);
        cyc(1'b1, a, d, 1'b0, 0);
    endtask

    task automatic tick(int st);
        cyc(1'b0, 0, 0, 1'b1, st);
    endtask

    task automatic setf(int v);
        wr(1, v & 'hFF);
        wr(2, v >> 8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", int'(freq_out), 0);
        chk("R1", int'(sweep_ovf), 0);
        rst_n = 1'b1;
        cyc(1'b0, 0, 0, 1'b0, 0);

        tag = "R2";
        wr(1, 'h34); wr(2, 'hFD);
        chk("R2", int'(freq_out), 'h534);
        wr(3, 'hFF);
        chk("R2", int'(freq_out), 'h534);

        tag = "R6";
        wr(0, 'h10);
        repeat (4) tick(2);
        chk("R6", int'(freq_out), 'h534);
        wr(0, 'h01);
        repeat (4) tick(6);
        chk("R6", int'(freq_out), 'h534);

        tag = "R3";
        wr(0, 'h91);
        setf('h100);
        for (int s = 0; s < 8; s++) if (s != 2 && s != 6) tick(s);
        cyc(1'b0, 0, 0, 1'b0, 2);
        chk("R3", int'(freq_out), 'h100);
        tag = "R4";
        tick(2);
        chk("R4", int'(freq_out), 'h100);
        tick(6);
        chk("R5", int'(freq_out), 'h180);

        wr(0, 'h32);
        repeat (3) tick(2);
        chk("R4", int'(freq_out), 'h180);
        tick(6);
        chk("R4", int'(freq_out), 'h1E0);

        tag = "R7";
        repeat (2) tick(2);
        wr(0, 'h32);
        repeat (3) tick(6);
        chk("R7", int'(freq_out), 'h1E0);
        tick(2);
        chk("R7", int'(freq_out), 'h258);

        tag = "R5";
        wr(0, 'h1B);
        setf('h400);
        repeat (2) tick(2);
        chk("R5", int'(freq_out), 'h380);
        repeat (2) tick(6);
        chk("R5", int'(freq_out), 'h310);

        tag = "R10";
        setf('h001);
        wr(0, 'h19);
        repeat (2) tick(2);
        chk("R10", int'(freq_out), 'h001);
        chk("R10", int'(sweep_ovf), 0);
        setf('h7FF);
        wr(0, 'h1F);
        repeat (2) tick(6);
        chk("R10", int'(freq_out), 'h7F0);

        tag = "R9";
        wr(0, 'h11);
        setf('h010);
        tick(2);
        cyc(1'b1, 1, 'h20, 1'b1, 6);
        chk("R9", int'(freq_out), 'h020);
        tick(2);
        chk("R9", int'(freq_out), 'h030);

        tag = "R8";
        wr(0, 'h11);
        setf('h555);
        repeat (2) tick(2);
        chk("R8", int'(freq_out), 'h7FF);
        chk("R8", int'(sweep_ovf), 0);
        repeat (2) tick(6);
        chk("R8", int'(freq_out), 'h7FF);
        chk("R8", int'(sweep_ovf), 1);
        repeat (4) tick(2);
        chk("R8", int'(sweep_ovf), 1);
        setf('h123);
        chk("R8", int'(freq_out), 'h123);
        wr(0, 'h1B);
        repeat (4) tick(6);
        chk("R8", int'(freq_out), 'h123);
        chk("R8", int'(sweep_ovf), 1);

        tag = "R1";
        rst_n = 1'b0;
        cyc(1'b0, 0, 0, 1'b0, 0);
        chk("R1", int'(freq_out), 0);
        chk("R1", int'(sweep_ovf), 0);
        rst_n = 1'b1;
        wr(0, 'h11);
        tick(2);
        chk("R1", int'(freq_out), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule